// File: doc/BRIEF.md
# Delay Line Length Calibrator

This block calibrates a tapped delay line so that one period of the sampling clock fits within a fixed number of delay taps. When it gets a start pulse, it steps a unit-delay code upward from zero. For each code it holds the line in its length-measurement configuration, waits for the line to report a measured length, and judges that length. The first acceptable code ends the sweep.

The result has two parts: the accepted unit code, and the highest usable phase index. The phase index is the position of the most significant set bit in the accepted length pattern. The result is announced with a single-cycle done pulse. If no code up to the top of the range is acceptable, the block emits a single-cycle error pulse instead. A code whose measurement never completes is abandoned after a timeout, and the sweep moves on to the next code.

Top module: `dline_cal`

## Requirements
- R1: A start pulse while idle begins a sweep at unit code 0. The code on `line_unit` then rises by exactly one per attempt, up to 2^UNIT_W-1 (127 by default).
- R2: While `line_smp` is high, `line_sel` equals TAPS+1 (12 by default) and `line_en` is high. `line_smp` is low for at least one cycle whenever a new unit code is applied, and `line_unit` does not change while `line_smp` is high.
- R3: A measurement, meaning `line_len` while `line_valid` is high during sampling, is accepted only if it is non-zero and below 2^TAPS (2048 by default). So 0x800 is rejected and 0x001 is accepted.
- R4: If `line_valid` does not rise within CLK_MHZ*TIMEOUT_US cycles of sampling, the code is skipped and the sweep continues with the next code.
- R5: `max_phase` is the bit index of the highest set bit of the accepted length, and is therefore below TAPS.
- R6: `done` is a pulse exactly one cycle long. `unit_out` and `max_phase` carry the result from that cycle on and hold it until the next start.
- R7: If every code through 2^UNIT_W-1 fails, `err` pulses for one cycle, `done` stays low, and `unit_out` and `max_phase` read 0.
- R8: A start pulse during a sweep is ignored. The sweep continues from its current code.
- R9: Synchronous reset returns the block to idle. `line_en`, `line_smp`, `done`, `err`, `unit_out` and `max_phase` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a calibration sweep |
| line_len | input | LEN_W | Length pattern measured by the delay line |
| line_valid | input | 1 | Length measurement complete |
| line_unit | output | UNIT_W | Unit-delay code driven to the line |
| line_sel | output | SEL_W | Tap select driven to the line |
| line_en | output | 1 | Delay line enable |
| line_smp | output | 1 | Length sampler enable |
| unit_out | output | UNIT_W | Accepted unit code |
| max_phase | output | MW | Highest usable phase index |
| done | output | 1 | Calibration succeeded (pulse) |
| err | output | 1 | No code was acceptable (pulse) |

## Verification
The bench builds the block with CLK_MHZ=1 and TIMEOUT_US=20, which gives a 20-cycle timeout. With that setting the timeout skip path can be exercised on several consecutive codes. A full 128-code failing sweep also fits in a few thousand cycles, so the error path can be reached. The remaining parameters keep their defaults, so the 2048 length bound and the tap select value of 12 are checked at their real values.

// File: rtl/dline_cal.sv
module dline_cal #(
  parameter int UNIT_W     = 7,
  parameter int SEL_W      = 4,
  parameter int LEN_W      = 12,
  parameter int TAPS       = 11,
  parameter int CLK_MHZ    = 100,
  parameter int TIMEOUT_US = 1000,
  localparam int MW        = $clog2(LEN_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  line_len,
  input  logic              line_valid,
  output logic [UNIT_W-1:0] line_unit,
  output logic [SEL_W-1:0]  line_sel,
  output logic              line_en,
  output logic              line_smp,
  output logic [UNIT_W-1:0] unit_out,
  output logic [MW-1:0]     max_phase,
  output logic              done,
  output logic              err
);
  localparam int CAL_SEL = TAPS + 1;
  localparam int TMO     = CLK_MHZ * TIMEOUT_US;
  localparam int TW      = $clog2(TMO + 1);
  localparam logic [UNIT_W-1:0] UNIT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_APPLY, S_WAIT, S_NEXT} st_t;
  st_t st;

  logic [UNIT_W-1:0] unit;
  logic [TW-1:0]     tmr;
  logic [MW-1:0]     msb;
  logic              len_ok, timeout;

  assign len_ok  = (|line_len) && (32'(line_len) < (32'd1 << TAPS));
  assign timeout = (tmr == TW'(TMO - 1));

  always_comb begin
    msb = '0;
    for (int i = 0; i < LEN_W; i++)
      if (line_len[i]) msb = MW'(i);
  end

  assign line_unit = unit;
  assign line_en   = (st != S_IDLE);
  assign line_smp  = (st == S_WAIT);
  assign line_sel  = line_en ? SEL_W'(CAL_SEL) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      unit      <= '0;
      tmr       <= '0;
      unit_out  <= '0;
      max_phase <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          unit      <= '0;
          unit_out  <= '0;
          max_phase <= '0;
          st        <= S_APPLY;
        end
        S_APPLY: begin
          tmr <= '0;
          st  <= S_WAIT;
        end
        S_WAIT: begin
          if (line_valid && len_ok) begin
            unit_out  <= unit;
            max_phase <= msb;
            done      <= 1'b1;
            st        <= S_IDLE;
          end else if (line_valid || timeout) begin
            st <= S_NEXT;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (unit == UNIT_MAX) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            unit <= unit + 1'b1;
            st   <= S_APPLY;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dline_cal_chk.sv
module dline_cal_chk #(
  parameter int UNIT_W = 7,
  parameter int SEL_W  = 4,
  parameter int TAPS   = 11,
  parameter int MW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [UNIT_W-1:0] line_unit,
  input logic [SEL_W-1:0]  line_sel,
  input logic              line_en,
  input logic              line_smp,
  input logic [MW-1:0]     max_phase,
  input logic              done,
  input logic              err
);
  p_sel_cal_r2: assert property (@(posedge clk) disable iff (rst)
    line_smp |-> (line_sel == SEL_W'(TAPS + 1)) && line_en);
  p_unit_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (line_smp && $past(line_smp)) |-> $stable(line_unit));
  p_phase_range_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (32'(max_phase) < TAPS));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_err_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  p_done_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  p_step_one_r1: assert property (@(posedge clk) disable iff (rst)
    (line_en && $past(line_en) && (line_unit != $past(line_unit)))
      |-> (line_unit == $past(line_unit) + 1'b1));
endmodule

bind dline_cal dline_cal_chk #(.UNIT_W(UNIT_W), .SEL_W(SEL_W), .TAPS(TAPS), .MW(MW)) i_chk (
  .clk(clk), .rst(rst), .line_unit(line_unit), .line_sel(line_sel),
  .line_en(line_en), .line_smp(line_smp), .max_phase(max_phase),
  .done(done), .err(err));

// File: tb/test_dline_cal.sv
module test_dline_cal;
  localparam int CLK_P = 10;
  localparam int LAT   = 3;

  logic clk = 0, rst = 1, start = 0;
  logic [11:0] line_len;
  logic line_valid;
  logic [6:0] line_unit, unit_out;
  logic [3:0] line_sel, max_phase;
  logic line_en, line_smp, done, err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int acc_unit, dead_below;
  logic [11:0] acc_len, rej_len;
  int cnt;

  always #(CLK_P/2) clk = ~clk;

  dline_cal #(.CLK_MHZ(1), .TIMEOUT_US(20)) i_dline_cal (
    .clk(clk), .rst(rst), .start(start), .line_len(line_len),
    .line_valid(line_valid), .line_unit(line_unit), .line_sel(line_sel),
    .line_en(line_en), .line_smp(line_smp), .unit_out(unit_out),
    .max_phase(max_phase), .done(done), .err(err));

  assign line_len = (int'(line_unit) == acc_unit) ? acc_len : rej_len;

  always @(posedge clk) begin
    if (!line_smp) begin cnt <= 0; line_valid <= 0; end
    else if (cnt == LAT) line_valid <= (int'(line_unit) >= dead_below);
    else cnt <= cnt + 1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run_cal(input logic exp_ok, input int exp_unit, input int exp_max, input string tag);
    int got_d, got_e, smp_seen;
    got_d = 0; got_e = 0; smp_seen = 0;
    pulse_start();
    for (int i = 0; i < 6000 && !got_d && !got_e; i++) begin
      @(negedge clk);
      if (line_smp && !smp_seen) begin
        smp_seen = 1;
        chk(line_sel == 4'd12 && line_en, {tag, " R2 sel"}, int'(line_sel), 12);
      end
      got_d = done; got_e = err;
    end
    chk(got_d == int'(exp_ok) && got_e == int'(!exp_ok), {tag, " R3/R7 outcome"}, got_d, int'(exp_ok));
    chk(int'(unit_out) == exp_unit, {tag, " R1 unit"}, int'(unit_out), exp_unit);
    chk(int'(max_phase) == exp_max, {tag, " R5 max"}, int'(max_phase), exp_max);
    @(negedge clk);
    chk(!done && !err, {tag, " R6 single pulse"}, int'(done | err), 0);
    chk(int'(unit_out) == exp_unit, {tag, " R6 hold"}, int'(unit_out), exp_unit);
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0; @(negedge clk);
    chk(!line_en && !line_smp && !done && !err && unit_out == 0 && max_phase == 0,
        "R9 reset state", int'(line_en), 0);
  endtask

  task automatic t_basic();
    acc_unit = 5; acc_len = 12'h03F; rej_len = 12'hFFF; dead_below = 0;
    run_cal(1, 5, 5, "R3 basic");
  endtask

  task automatic t_bound();
    acc_unit = 3; acc_len = 12'h001; rej_len = 12'h800; dead_below = 0;
    run_cal(1, 3, 0, "R3 bound");
    acc_unit = 0; acc_len = 12'h7FF; rej_len = 12'h000;
    run_cal(1, 0, 10, "R5 top");
  endtask

  task automatic t_timeout();
    acc_unit = 4; acc_len = 12'h0F0; rej_len = 12'h000; dead_below = 4;
    run_cal(1, 4, 7, "R4 timeout");
  endtask

  task automatic t_allfail();
    acc_unit = 500; acc_len = 0; rej_len = 12'h000; dead_below = 120;
    run_cal(0, 0, 0, "R7 all fail");
  endtask

  task automatic t_busy_start();
    int u;
    acc_unit = 10; acc_len = 12'h100; rej_len = 12'h000; dead_below = 0;
    pulse_start();
    while (line_unit != 7'd6) @(negedge clk);
    u = int'(line_unit);
    start = 1; @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    chk(int'(line_unit) >= u, "R8 busy start ignored", int'(line_unit), u);
    while (!done) @(negedge clk);
    chk(unit_out == 7'd10 && max_phase == 4'd8, "R8 result", int'(unit_out), 10);
  endtask

  task automatic t_mid_reset();
    acc_unit = 50; acc_len = 12'h010; rej_len = 12'h000; dead_below = 0;
    pulse_start();
    repeat (40) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk(!line_en && !line_smp && unit_out == 0, "R9 mid reset", int'(line_en), 0);
    repeat (20) @(negedge clk);
    chk(!line_en && !done, "R9 stays idle", int'(line_en), 0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    acc_unit = 0; acc_len = 0; rej_len = 0; dead_below = 0;
    t_reset();
    t_basic();
    t_bound();
    t_timeout();
    t_allfail();
    t_busy_start();
    t_mid_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule